// File: doc/BRIEF.md
# Infrared Front-End Control Logic

This block models the digital control of an infrared transceiver front end. It sits between a serial encoder/decoder and the optical parts. A shutdown input puts the block to sleep. A transmit-data input drives the emitter. An abstract detect input stands for light above the receiver threshold. The outputs are an emitter enable, an active-low receive line with its own output enable, and a flag that reports the receiver bandwidth setting.

The bandwidth setting has no pin of its own. It is programmed by the level of the transmit line at the moment shutdown is released. A low level selects the narrow band used for slow serial infrared rates (up to 115.2 kbit/s). A high level selects the wide band used for 0.576 to 4 Mbit/s. The transmit line has a watchdog that turns the emitter off if one pulse lasts too long. After shutdown is released, the receiver waits through a start-up time before it reports anything.

All inputs are asynchronous and pass through two-flop synchronizers. The clock rate is a parameter, and the watchdog limit and the start-up time are given in microseconds and converted to cycle counts at elaboration.

Top module: `ir_frontend_ctrl`

## Requirements
- R1: On each falling edge of the synchronized shutdown input, `band_o` takes the synchronized transmit level of that same cycle. Encoding: 0 is the narrow band, 1 is the wide band.
- R2: After reset `band_o` is 0 (narrow band).
- R3: While shutdown is high, `emit_o` is 0, `rx_oe_o` is 0 (the line is released to its pull-up) and `rx_n_o` is 1. This holds even when detect or transmit is high.
- R4: `emit_o` is 1 only while shutdown is low and transmit is high. A transmit pulse of N cycles, with N below the limit, gives exactly N emitter cycles.
- R5: If transmit stays high for longer than GUARD_US microseconds, the emitter stops after exactly that many cycles (GUARD_US × CLK_HZ/10^6) and stays off while transmit is still high.
- R6: The watchdog re-arms only when transmit returns low. A later pulse again gets the full window.
- R7: Once the receiver is ready, `rx_n_o` is 0 while detect is high and 1 while detect is low.
- R8: Once the receiver is ready, `rx_n_o` is also 0 in every cycle in which `emit_o` is 1. The receive line echoes the transmitted pulse.
- R9: For WAKE_US microseconds after shutdown is released, `rx_n_o` stays 1 whatever detect does, while `rx_oe_o` is already 1.
- R10: `band_o` holds its value when shutdown rises or transmit toggles. It changes only on a shutdown falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_i | input | 1 | Shutdown request; also strobes the band setting on release |
| tx_i | input | 1 | Transmit data; also carries the band choice |
| detect_i | input | 1 | Abstract optical detection above threshold |
| emit_o | output | 1 | Emitter driver enable |
| rx_n_o | output | 1 | Receive data, active low |
| rx_oe_o | output | 1 | Output enable for the receive line |
| band_o | output | 1 | Bandwidth setting: 0 narrow, 1 wide |

## Verification
The hardest state to reach is the watchdog cut-off followed by a clean re-arm. Transmit must stay high through the full window with shutdown low, drop, and then rise again for a second long pulse. The bench sets the clock-rate parameter so that one microsecond is one cycle. It then counts emitter cycles over a short pulse, a long pulse and a repeated long pulse, and compares each count with the smaller of the pulse length and the window. The start-up hold is reached by raising detect while the block is still in shutdown. The receive line is then sampled just before and just after the start-up time ends.

// File: rtl/ir_ctrl_pkg.sv
package ir_ctrl_pkg;

  typedef enum logic {
    BAND_NARROW = 1'b0,
    BAND_WIDE   = 1'b1
  } band_e;

  // cycles spanned by a time given in microseconds
  function automatic int unsigned us_to_cycles(input int unsigned clk_hz,
                                               input int unsigned us);
    int unsigned per_us;
    per_us = clk_hz / 1000000;
    if (per_us == 0) per_us = 1;
    if (us == 0) return 1;
    return per_us * us;
  endfunction

  // counter width able to hold limit-1
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 3) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/ir_sync.sv
module ir_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ir_band_latch.sv
module ir_band_latch
  import ir_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sd_s,
  input  logic  tx_s,
  output logic  sd_fall,
  output band_e band
);
  logic sd_q;

  assign sd_fall = sd_q & ~sd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q <= 1'b1;
      band <= BAND_NARROW;
    end else begin
      sd_q <= sd_s;
      if (sd_fall) band <= tx_s ? BAND_WIDE : BAND_NARROW;
    end
  end
endmodule

// File: rtl/ir_tx_guard.sv
module ir_tx_guard #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sd_s,
  input  logic tx_s,
  output logic emit,
  output logic tripped
);
  localparam int unsigned CW = ir_ctrl_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      tripped <= 1'b0;
    end else if (!tx_s) begin
      run_cnt <= '0;
      tripped <= 1'b0;
    end else if (!tripped) begin
      if (run_cnt == LAST) tripped <= 1'b1;
      else run_cnt <= run_cnt + 1'b1;
    end
  end

  assign emit = tx_s & ~sd_s & ~tripped;
endmodule

// File: rtl/ir_rx_path.sv
module ir_rx_path #(
  parameter int unsigned WAKE = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sd_s,
  input  logic det_s,
  input  logic emit,
  output logic ready,
  output logic rx_n,
  output logic rx_oe
);
  localparam int unsigned CW = ir_ctrl_pkg::cnt_width(WAKE);
  localparam logic [CW-1:0] LAST = CW'(WAKE - 1);

  logic [CW-1:0] wake_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_cnt <= '0;
      ready    <= 1'b0;
    end else if (sd_s) begin
      wake_cnt <= '0;
      ready    <= 1'b0;
    end else if (!ready) begin
      if (wake_cnt == LAST) ready <= 1'b1;
      else wake_cnt <= wake_cnt + 1'b1;
    end
  end

  assign rx_oe = ~sd_s;
  assign rx_n  = ~(ready & ~sd_s & (det_s | emit));
endmodule

// File: rtl/ir_frontend_ctrl.sv
module ir_frontend_ctrl
  import ir_ctrl_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 200000000,
  parameter int unsigned GUARD_US = 100,
  parameter int unsigned WAKE_US  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_i,
  input  logic tx_i,
  input  logic detect_i,
  output logic emit_o,
  output logic rx_n_o,
  output logic rx_oe_o,
  output logic band_o
);
  localparam int unsigned GUARD_CYC = us_to_cycles(CLK_HZ, GUARD_US);
  localparam int unsigned WAKE_CYC  = us_to_cycles(CLK_HZ, WAKE_US);

  // named internal events, visible to the bound checker
  logic  sd_s, tx_s, det_s;
  logic  sd_fall, tripped, rx_ready;
  band_e band;

  ir_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({shdn_i, tx_i, detect_i}),
    .q_o   ({sd_s, tx_s, det_s})
  );

  ir_band_latch u_band (
    .clk     (clk),
    .rst_n   (rst_n),
    .sd_s    (sd_s),
    .tx_s    (tx_s),
    .sd_fall (sd_fall),
    .band    (band)
  );

  ir_tx_guard #(.LIMIT(GUARD_CYC)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .sd_s    (sd_s),
    .tx_s    (tx_s),
    .emit    (emit_o),
    .tripped (tripped)
  );

  ir_rx_path #(.WAKE(WAKE_CYC)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .sd_s  (sd_s),
    .det_s (det_s),
    .emit  (emit_o),
    .ready (rx_ready),
    .rx_n  (rx_n_o),
    .rx_oe (rx_oe_o)
  );

  assign band_o = (band == BAND_WIDE);
endmodule

// File: rtl/ir_frontend_ctrl_chk.sv
module ir_frontend_ctrl_chk #(
  parameter int unsigned GUARD_CYC = 100
) (
  input logic clk,
  input logic rst_n,
  input logic sd_s,
  input logic tx_s,
  input logic sd_fall,
  input logic tripped,
  input logic rx_ready,
  input logic emit_o,
  input logic rx_n_o,
  input logic rx_oe_o,
  input logic band_o
);
  int unsigned emit_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) emit_run <= 0;
    else if (emit_o) emit_run <= emit_run + 1;
    else emit_run <= 0;
  end

  // R1
  band_follows_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_fall |=> band_o == $past(tx_s));

  // R10
  band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_fall |=> $stable(band_o));

  // R3
  shdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_s |-> (!emit_o && !rx_oe_o && rx_n_o));

  // R4
  emit_needs_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit_o |-> (tx_s && !sd_s));

  // R5
  emit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit_run <= GUARD_CYC);

  // R5
  trip_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> !emit_o);

  // R6
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_s) |=> !tripped);

  // R9
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> rx_n_o);

  // R8
  echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && emit_o) |-> !rx_n_o);
endmodule

bind ir_frontend_ctrl ir_frontend_ctrl_chk #(.GUARD_CYC(GUARD_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sd_s     (sd_s),
  .tx_s     (tx_s),
  .sd_fall  (sd_fall),
  .tripped  (tripped),
  .rx_ready (rx_ready),
  .emit_o   (emit_o),
  .rx_n_o   (rx_n_o),
  .rx_oe_o  (rx_oe_o),
  .band_o   (band_o)
);

// File: tb/ir_frontend_ctrl_tb.sv
module ir_frontend_ctrl_tb_top;
  localparam int unsigned CLK_HZ = 1000000;   // one cycle per microsecond
  localparam int unsigned GUARD  = 100;
  localparam int unsigned WAKE   = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shdn = 1'b1, tx = 1'b0, det = 1'b0;
  logic emit, rx_n, rx_oe, band;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // item bits: [3] band, [2] oe, [1] rx_n, [0] emit ; upper nibble = mask
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  ir_frontend_ctrl #(.CLK_HZ(CLK_HZ), .GUARD_US(GUARD), .WAKE_US(WAKE)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shdn_i   (shdn),
    .tx_i     (tx),
    .detect_i (det),
    .emit_o   (emit),
    .rx_n_o   (rx_n),
    .rx_oe_o  (rx_oe),
    .band_o   (band)
  );

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_out(input logic [3:0] mask, input logic [3:0] val, input string tag);
    exp_q.push_back({mask, val});
    tag_q.push_back(tag);
  endtask

  task automatic compare_int(input int act, input int expv, input string tag);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor: pops and compares scoreboard items
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [7:0] it;
      string      tg;
      logic [3:0] act;
      it  = exp_q.pop_front();
      tg  = tag_q.pop_front();
      act = {band, rx_oe, rx_n, emit};
      checks++;
      if ((act & it[7:4]) !== (it[3:0] & it[7:4])) begin
        errors++;
        $display("FAIL %s: actual band/oe/rxn/emit=%b expected %b (mask %b)",
                 tg, act, it[3:0], it[7:4]);
      end
    end
  end

  task automatic pulse_count(input int n, input string tag);
    int cnt = 0;
    tx = 1'b1;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (emit) cnt++;
      if (i == n - 3 && n > GUARD + 3) expect_out(4'b0001, 4'b0000, {tag, " emitter off while tx still high"});
    end
    tx = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      if (emit) cnt++;
    end
    compare_int(cnt, (n < GUARD) ? n : GUARD, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    // R2 R3: state under reset
    expect_out(4'b1111, 4'b0010, "R2 R3 in reset");
    tick(3);
    rst_n = 1'b1;
    tick(3);
    expect_out(4'b1111, 4'b0010, "R2 R3 after reset");

    // R3: shutdown masks tx and detect
    tx = 1'b1; det = 1'b1;
    tick(5);
    expect_out(4'b0111, 4'b0010, "R3 shutdown with tx and detect high");
    tx = 1'b0; det = 1'b0;
    tick(4);

    // R1: program wide band
    tx = 1'b1;
    tick(3);
    shdn = 1'b0;
    tick(3);
    tx = 1'b0;
    tick(4);
    expect_out(4'b1100, 4'b1100, "R1 wide band latched");

    // R10: tx toggles and shutdown rises without changing band
    tx = 1'b1; tick(3); tx = 1'b0; tick(3);
    expect_out(4'b1000, 4'b1000, "R10 tx toggle keeps band");
    shdn = 1'b1;
    tick(5);
    expect_out(4'b1000, 4'b1000, "R10 shutdown rise keeps band");

    // R1 R9: program narrow band, detect high during start-up
    det = 1'b1;
    tick(4);
    shdn = 1'b0;
    tick(WAKE - 5);
    expect_out(4'b1110, 4'b0110, "R9 rx held high during start-up");
    tick(10);
    expect_out(4'b1110, 4'b0100, "R1 R7 narrow band, detect seen when ready");
    det = 1'b0;
    tick(4);
    expect_out(4'b0010, 4'b0010, "R7 rx high when detect low");

    // R4 R8: short pulse, echo on receive line
    tx = 1'b1;
    tick(4);
    expect_out(4'b0011, 4'b0001, "R4 R8 emitting and echo");
    tx = 1'b0;
    tick(6);
    pulse_count(10, "R4 short pulse length");

    // R5 R6: over-long pulses
    pulse_count(GUARD + 50, "R5 watchdog cut");
    tick(5);
    pulse_count(GUARD + 30, "R6 re-armed full window");
    pulse_count(GUARD - 1, "R6 pulse just under limit");

    // R3: return to shutdown releases outputs
    shdn = 1'b1; det = 1'b1;
    tick(5);
    expect_out(4'b0111, 4'b0010, "R3 shutdown again");
    tick(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule